// File: doc/BRIEF.md
# Smart Card Power-Down Sequencer

This block takes a contact smart card interface down in a fixed order at the end of a card session. A host session bit (high means a session is wanted) brings the interface up. A set of hardware fault flags and a card-present input are watched as well. While a session is live, the card reset, clock and data outputs follow the levels from the card-side logic, each through one register stage, and the card supply enable is high.

The power-down starts in one of two ways: the host drops the session bit, or the hardware ends the session through a fault flag or card removal. The block then forces card reset low, then card clock low, then card data low, and last turns the supply enable off. Each step waits its own number of system clock cycles, set by parameters. The defaults are 0.5 µs, 7.5 µs, 0.5 µs and 0.5 µs at 100 MHz. Once started, the sequence always runs to the end. A busy flag covers the whole sequence, and a one-cycle done pulse marks its end. Reset is synchronous and active high, and every output is registered.

Top module: `card_pwrdn_seq`

## Requirements
- R1: While reset is high and afterwards in idle, card_rst, card_clk, card_io, vcc_en, busy and done are all low.
- R2: In idle, once armed, a cycle with sess_req high, card_here high and fault_in all zero moves the block to the live state. From the next clock edge vcc_en is high and each card line equals its live_* input as sampled at the previous edge.
- R3: In the live state, sess_req low at a clock edge (the trigger edge) starts the power-down, and busy is high from that edge.
- R4: In the live state, any set bit of fault_in (bit 0 over-current, bit 1 over-temperature, bit 2 supply fault) or card_here low at an edge also starts the same power-down.
- R5: card_rst is forced low from T1_CYC edges after the trigger edge. Until then it keeps following live_rst.
- R6: card_clk is forced low from T1_CYC+T2_CYC edges after the trigger edge, and follows live_clk until then.
- R7: card_io is forced low from T1_CYC+T2_CYC+T3_CYC edges after the trigger edge, and follows live_io until then.
- R8: vcc_en and busy drop T1_CYC+T2_CYC+T3_CYC+T4_CYC edges after the trigger edge. done is high for exactly that one following cycle.
- R9: Changes on sess_req, fault_in or card_here during the power-down neither restart nor shorten it.
- R10: After reset or after any power-down, the block is armed only once sess_req has been seen low in idle. Until then a high sess_req does not turn vcc_en on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sess_req | input | 1 | Host session bit, 1 = session wanted |
| fault_in | input | NFAULT | Fault flags: [0] over-current, [1] over-temperature, [2] supply |
| card_here | input | 1 | Card present |
| live_rst | input | 1 | Card reset level from the session logic |
| live_clk | input | 1 | Card clock level from the session logic |
| live_io | input | 1 | Card data level from the session logic |
| card_rst | output | 1 | Gated card reset |
| card_clk | output | 1 | Gated card clock |
| card_io | output | 1 | Gated card data |
| vcc_en | output | 1 | Card supply enable |
| busy | output | 1 | Power-down in progress |
| done | output | 1 | One-cycle pulse at the end of the power-down |

## Verification
The sequence is started by each trigger on its own: a host clear, each of the three fault bits, and card removal. The stop times of all four steps are identical for every trigger, which shows that all sources share one path. Fault bursts and session-bit toggles are injected in the middle of a sequence; an unchanged sequence length shows that late events neither restart nor cut it short. Random live levels on the card inputs show, cycle by cycle, which lines still pass and which are forced. Runs where a fault leaves the session bit high show that the block does not power up again until the bit has been seen low.

// File: rtl/cpd_pkg.sv
package cpd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LIVE  = 3'd1,
    ST_STEP1 = 3'd2,
    ST_STEP2 = 3'd3,
    ST_STEP3 = 3'd4,
    ST_STEP4 = 3'd5
  } cpd_state_e;

  localparam int NLINE = 3;
  localparam int LN_RST = 0;
  localparam int LN_CLK = 1;
  localparam int LN_IO  = 2;
endpackage

// File: rtl/cpd_trigger.sv
module cpd_trigger #(
  parameter int NFAULT = 3
) (
  input  logic              sess_req,
  input  logic [NFAULT-1:0] fault_in,
  input  logic              card_here,
  output logic              stop_req,
  output logic              start_ok
);
  logic any_fault;

  always_comb begin
    any_fault = |fault_in;
    stop_req  = !sess_req || any_fault || !card_here;
    start_ok  = sess_req && card_here && !any_fault;
  end
endmodule

// File: rtl/cpd_step_timer.sv
module cpd_step_timer #(
  parameter int T1_CYC = 50,
  parameter int T2_CYC = 750,
  parameter int T3_CYC = 50,
  parameter int T4_CYC = 50,
  parameter int CW     = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [1:0] step_sel,
  output logic       expire
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim_m1;

  always_comb begin
    case (step_sel)
      2'd0:    lim_m1 = CW'(T1_CYC - 1);
      2'd1:    lim_m1 = CW'(T2_CYC - 1);
      2'd2:    lim_m1 = CW'(T3_CYC - 1);
      default: lim_m1 = CW'(T4_CYC - 1);
    endcase
    expire = run && (cnt == lim_m1);
  end

  always_ff @(posedge clk) begin
    if (rst || !run || expire) cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    run |-> cnt <= lim_m1);  // R9
endmodule

// File: rtl/cpd_line_gate.sv
module cpd_line_gate #(
  parameter int NLINE = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NLINE-1:0] live,
  input  logic [NLINE-1:0] pass_nxt,
  input  logic             vcc_nxt,
  output logic [NLINE-1:0] line_q,
  output logic             vcc_q
);
  for (genvar i = 0; i < NLINE; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) line_q[i] <= 1'b0;
      else     line_q[i] <= live[i] & pass_nxt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) vcc_q <= 1'b0;
    else     vcc_q <= vcc_nxt;
  end
endmodule

// File: rtl/card_pwrdn_seq.sv
module card_pwrdn_seq
  import cpd_pkg::*;
#(
  parameter int NFAULT = 3,
  parameter int T1_CYC = 50,
  parameter int T2_CYC = 750,
  parameter int T3_CYC = 50,
  parameter int T4_CYC = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sess_req,
  input  logic [NFAULT-1:0] fault_in,
  input  logic              card_here,
  input  logic              live_rst,
  input  logic              live_clk,
  input  logic              live_io,
  output logic              card_rst,
  output logic              card_clk,
  output logic              card_io,
  output logic              vcc_en,
  output logic              busy,
  output logic              done
);
  localparam int TMAX_A = (T1_CYC > T2_CYC) ? T1_CYC : T2_CYC;
  localparam int TMAX_B = (T3_CYC > T4_CYC) ? T3_CYC : T4_CYC;
  localparam int TMAX   = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
  localparam int CW     = $clog2(TMAX + 1);

  cpd_state_e       st, st_nxt;
  logic             armed;
  logic             stop_req, start_ok;
  logic             run, expire;
  logic [1:0]       step_sel;
  logic [NLINE-1:0] pass_nxt;
  logic [NLINE-1:0] line_q;
  logic             vcc_nxt;

  cpd_trigger #(.NFAULT(NFAULT)) trig_i (
    .sess_req (sess_req),
    .fault_in (fault_in),
    .card_here(card_here),
    .stop_req (stop_req),
    .start_ok (start_ok)
  );

  cpd_step_timer #(
    .T1_CYC(T1_CYC), .T2_CYC(T2_CYC), .T3_CYC(T3_CYC), .T4_CYC(T4_CYC), .CW(CW)
  ) tmr_i (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .step_sel(step_sel),
    .expire  (expire)
  );

  always_comb begin
    run      = 1'b1;
    step_sel = 2'd0;
    case (st)
      ST_STEP1: step_sel = 2'd0;
      ST_STEP2: step_sel = 2'd1;
      ST_STEP3: step_sel = 2'd2;
      ST_STEP4: step_sel = 2'd3;
      default:  run      = 1'b0;
    endcase
  end

  always_comb begin
    st_nxt = st;
    case (st)
      ST_IDLE:  if (armed && start_ok) st_nxt = ST_LIVE;
      ST_LIVE:  if (stop_req)          st_nxt = ST_STEP1;
      ST_STEP1: if (expire)            st_nxt = ST_STEP2;
      ST_STEP2: if (expire)            st_nxt = ST_STEP3;
      ST_STEP3: if (expire)            st_nxt = ST_STEP4;
      ST_STEP4: if (expire)            st_nxt = ST_IDLE;
      default:                         st_nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    pass_nxt = '0;
    case (st_nxt)
      ST_LIVE, ST_STEP1: pass_nxt = '1;
      ST_STEP2: begin
        pass_nxt[LN_CLK] = 1'b1;
        pass_nxt[LN_IO]  = 1'b1;
      end
      ST_STEP3: pass_nxt[LN_IO] = 1'b1;
      default:  pass_nxt = '0;
    endcase
    vcc_nxt = (st_nxt != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      armed <= 1'b0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      st   <= st_nxt;
      busy <= (st_nxt == ST_STEP1) || (st_nxt == ST_STEP2) ||
              (st_nxt == ST_STEP3) || (st_nxt == ST_STEP4);
      done <= (st == ST_STEP4) && expire;
      if (st == ST_IDLE && !sess_req)      armed <= 1'b1;
      else if (st == ST_LIVE && stop_req)  armed <= 1'b0;
    end
  end

  cpd_line_gate #(.NLINE(NLINE)) gate_i (
    .clk     (clk),
    .rst     (rst),
    .live    ({live_io, live_clk, live_rst}),
    .pass_nxt(pass_nxt),
    .vcc_nxt (vcc_nxt),
    .line_q  (line_q),
    .vcc_q   (vcc_en)
  );

  assign card_rst = line_q[LN_RST];
  assign card_clk = line_q[LN_CLK];
  assign card_io  = line_q[LN_IO];

  AST_OFF_LINES_LOW: assert property (@(posedge clk) disable iff (rst)
    !vcc_en |-> (!card_rst && !card_clk && !card_io));  // R1
  AST_BUSY_POWERED: assert property (@(posedge clk) disable iff (rst)
    busy |-> vcc_en);  // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R8
  AST_VCC_OFF_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(vcc_en) |-> done);  // R8
  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);  // R9
  AST_STEP3_ORDER: assert property (@(posedge clk) disable iff (rst)
    (st == ST_STEP3) |-> (!card_rst && !card_clk));  // R6
  AST_STEP2_ORDER: assert property (@(posedge clk) disable iff (rst)
    (st == ST_STEP2) |-> !card_rst);  // R5
  AST_REARM_NEEDED: assert property (@(posedge clk) disable iff (rst)
    $rose(vcc_en) |-> $past(armed));  // R10
endmodule

// File: tb/card_pwrdn_seq_tb_top.sv
module card_pwrdn_seq_tb_top;
  localparam int NF  = 3;
  localparam int T1  = 4;
  localparam int T2  = 11;
  localparam int T3  = 2;
  localparam int T4  = 6;
  localparam int TOT = T1 + T2 + T3 + T4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sess_req = 1'b0;
  logic [NF-1:0] fault_in = '0;
  logic card_here = 1'b1;
  logic live_rst = 1'b0, live_clk = 1'b0, live_io = 1'b0;
  logic card_rst, card_clk, card_io, vcc_en, busy, done;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit started = 1'b0;

  always #5 clk = ~clk;

  card_pwrdn_seq #(
    .NFAULT(NF), .T1_CYC(T1), .T2_CYC(T2), .T3_CYC(T3), .T4_CYC(T4)
  ) dut_i (
    .clk(clk), .rst(rst), .sess_req(sess_req), .fault_in(fault_in),
    .card_here(card_here), .live_rst(live_rst), .live_clk(live_clk),
    .live_io(live_io), .card_rst(card_rst), .card_clk(card_clk),
    .card_io(card_io), .vcc_en(vcc_en), .busy(busy), .done(done)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic end_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  // reference model
  int m_mode = 0;  // 0 idle, 1 live, 2 powering down
  int m_el   = 0;
  bit m_arm  = 0;
  bit e_rst, e_clk, e_io, e_vcc, e_busy, e_done;

  function automatic bit passes(int mode, int el, int lim, bit lv);
    return lv && (mode == 1 || (mode == 2 && el < lim));
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_mode = 0; m_el = 0; m_arm = 0; e_done = 0;
    end else begin
      e_done = 0;
      case (m_mode)
        0: if (sess_req && m_arm && card_here && fault_in == '0) m_mode = 1;
           else if (!sess_req) m_arm = 1;
        1: if (!sess_req || fault_in != '0 || !card_here) begin
             m_mode = 2; m_el = 0; m_arm = 0;
           end
        default: begin
          m_el++;
          if (m_el == TOT) begin m_mode = 0; e_done = 1; end
        end
      endcase
    end
    e_rst  = passes(m_mode, m_el, T1, live_rst);
    e_clk  = passes(m_mode, m_el, T1 + T2, live_clk);
    e_io   = passes(m_mode, m_el, T1 + T2 + T3, live_io);
    e_vcc  = (m_mode != 0);
    e_busy = (m_mode == 2);
  end

  always @(negedge clk) begin
    if (started) begin
      if (m_mode == 0) begin
        string t = (!m_arm && sess_req) ? "R10" : "R1";
        chk(t, "vcc_en", vcc_en, e_vcc);
        chk(t, "card lines", {card_io, card_clk, card_rst}, 0);
        chk("R8", "done", done, e_done);
        chk("R1", "busy", busy, 0);
      end else if (m_mode == 1) begin
        chk("R2", "card_rst", card_rst, e_rst);
        chk("R2", "card_clk", card_clk, e_clk);
        chk("R2", "card_io", card_io, e_io);
        chk("R2", "vcc_en", vcc_en, 1);
        chk("R2", "busy", busy, 0);
      end else begin
        chk("R5", "card_rst", card_rst, e_rst);
        chk("R6", "card_clk", card_clk, e_clk);
        chk("R7", "card_io", card_io, e_io);
        chk("R8", "vcc_en", vcc_en, e_vcc);
        chk("R8", "busy", busy, e_busy);
        chk("R8", "done", done, 0);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      end_run();
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #2;
      live_rst = $urandom_range(0, 1);
      live_clk = $urandom_range(0, 1);
      live_io  = $urandom_range(0, 1);
    end
  endtask

  task automatic activate();
    sess_req = 0; fault_in = '0; card_here = 1;
    step(2);
    sess_req = 1;
    step(2);
    chk("R2", "vcc_en after request", vcc_en, 1);
  endtask

  // counts busy cycles from the trigger until done; optional mid-run disturbance
  task automatic measure(input string tag, input bit disturb, output int len);
    int n = 0;
    bit seen_done = 0;
    for (int g = 0; g < 4 * TOT && !seen_done; g++) begin
      @(negedge clk); #2;
      live_rst = $urandom_range(0, 1);
      live_clk = $urandom_range(0, 1);
      live_io  = $urandom_range(0, 1);
      if (g == 0) chk(tag, "busy right after trigger", busy, 1);
      if (busy) n++;
      else if (done) seen_done = 1;
      if (disturb && g == T1 + 1) begin sess_req = 1; fault_in = 3'b111; card_here = 0; end
      if (disturb && g == T1 + 3) begin fault_in = '0; card_here = 1; end
      if (disturb && g == T1 + T2 + 1) sess_req = 0;
      if (disturb && g == T1 + T2 + 3) sess_req = 1;
    end
    len = n;
  endtask

  initial begin
    int len;
    void'($urandom(32'h5EED_0A17));
    rst = 1;
    step(3);
    chk("R1", "vcc_en in reset", vcc_en, 0);
    chk("R1", "card lines in reset", {card_io, card_clk, card_rst}, 0);
    rst = 0;
    started = 1;
    sess_req = 1;
    step(4);
    chk("R10", "no power-up before arming", vcc_en, 0);

    // host clear
    activate();
    step(3);
    sess_req = 0;
    measure("R3", 0, len);
    chk("R8", "sequence length host clear", len, TOT);

    // each fault bit, then card removal
    for (int f = 0; f < NF + 1; f++) begin
      activate();
      step(2);
      if (f < NF) fault_in[f] = 1'b1; else card_here = 0;
      measure("R4", 0, len);
      chk("R4", "sequence length fault source", len, TOT);
      fault_in = '0; card_here = 1;
      step(6);
      chk("R10", "stays off with session bit high", vcc_en, 0);
    end

    // disturbances during power-down
    activate();
    sess_req = 0;
    measure("R3", 1, len);
    chk("R9", "sequence length with disturbance", len, TOT);

    // re-arm after low
    sess_req = 0; step(2); sess_req = 1; step(2);
    chk("R10", "power-up after re-arm", vcc_en, 1);

    // random phase
    for (int i = 0; i < 8000; i++) begin
      step(1);
      if ($urandom_range(0, 19) == 0) sess_req = ~sess_req;
      fault_in = '0;
      if ($urandom_range(0, 149) == 0) fault_in[$urandom_range(0, NF - 1)] = 1'b1;
      card_here = ($urandom_range(0, 249) != 0);
    end
    step(2 * TOT);
    end_run();
  end
endmodule